// File: doc/BRIEF.md
# Clock Control Unit with Divide-by-32 Slow Mode

This block picks the CPU clock for a small microcontroller core. The CPU clock is either the oscillator clock or a copy of it divided by 32. A free-running 5-bit divider provides the slow clock. A mode change takes effect only at a fixed point of the divider, when both candidate clocks are low, so the switch never produces a short pulse. The same point gates a clock-out pin. That pin carries the CPU clock when it is enabled and is handed back to general-purpose I/O when it is disabled.

Software reaches the unit through a one-bit-address register bus.

- Address 0 is the control register. Bit 1 enables the clock-out pin and bit 0 selects slow mode. Bits 7:2 are reserved.
- Address 1 is a read-only status register. Bit 0 is a lock flag.

The lock flag rises only after two waits. The first is a startup wait of fixed length after reset or after leaving halt. The second is a stabilisation wait during which the synchronised PLL-locked input must stay high without a break.

Top module: `clkctl`

## Requirements
- R1: After reset, address 0 reads 00h, address 1 reads 00h, `cko_oe_o` is 0 and `cpu_clk_o` follows `clk_i`.
- R2: Bits 7:2 of address 0 ignore writes and always read 0.
- R3: Bit 1 of address 0 is the clock-out enable, and its applied value drives `cko_oe_o`.
  - With the applied value at 1, `cko_o` equals `cpu_clk_o`.
  - With the applied value at 0, `cko_o` stays 0.
- R4: Bit 0 of address 0 selects slow mode.
  - With the applied value at 1, `cpu_clk_o` is high exactly while the divider count (rising `clk_i` edges since reset, modulo 32) is 16 to 31. This gives a period of 32 oscillator periods.
  - With the applied value at 0, `cpu_clk_o` equals `clk_i`.
- R5: Bits 1:0 of address 0 read back the last value written. A write to address 1 changes nothing.
- R6: A written mode or clock-out-enable value is applied at the first falling `clk_i` edge at which the divider count is 0 and the new value is already registered.
- R7: After reset, bit 0 of address 1 reads 1 from the (STARTUP_CYC+STAB_CYC)-th rising edge onward, provided `pll_lock_i` is held high. It reads 0 before that edge.
- R8: If `pll_lock_i` falls, the lock flag clears on the third rising edge. Once the input returns high, the flag is set again STAB_CYC+2 edges later.
- R9: While `halt_i` is high the lock flag is 0. Counting restarts from the first edge with `halt_i` low, and the flag sets after STARTUP_CYC+STAB_CYC such edges.
- R10: The lock flag is read-only: bus writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 1 | 0: control, 1: status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pll_lock_i | input | 1 | Asynchronous PLL-locked indication |
| halt_i | input | 1 | Halt state indication, clears the lock flag |
| cpu_clk_o | output | 1 | Selected CPU clock |
| cko_o | output | 1 | Clock-out pin data |
| cko_oe_o | output | 1 | Clock-out pin ownership: 1 clock, 0 general I/O |

## Verification
The bench builds the unit with the real five-bit divider and with STARTUP_CYC=8, STAB_CYC=12 and a two-stage synchroniser. Every divider phase of the slow clock is compared against the arithmetic count/16 rule. The short waits make it possible to sweep the lock flag at every edge from reset, from the end of halt and from the recovery of the PLL input. The bench also tracks the divider phase on its own, which lets it predict the exact edge at which a written mode takes effect.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic cko_en;
    logic slow;
  } ctrl_t;

  typedef enum logic [1:0] {
    LK_START = 2'd0,
    LK_STAB  = 2'd1,
    LK_DONE  = 2'd2
  } lock_st_e;
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  input  logic       locked_i,
  output ctrl_t      ctrl_o,
  output logic [7:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  wr_ctrl;

  assign wr_ctrl = sel_i && we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[1:0]);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) rdata_o[1:0] = ctrl_q;
    else                     rdata_o[0]   = locked_i;
  end

  assign ctrl_o = ctrl_q;

  a_r5_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(ctrl_q));
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:2] == 6'd0);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
  import clkctl_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  output logic  cpu_clk_o,
  output logic  cko_o,
  output logic  cko_oe_o
);
  localparam int CW = DIV_LOG2;

  logic [CW-1:0] cnt_q;
  logic          slow_act_q;
  logic          cko_act_q;
  logic          at_bound;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  // count 0 sampled at the falling edge: oscillator and divided clock both low
  assign at_bound = (cnt_q == '0);

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      slow_act_q <= 1'b0;
      cko_act_q  <= 1'b0;
    end else if (at_bound) begin
      slow_act_q <= ctrl_i.slow;
      cko_act_q  <= ctrl_i.cko_en;
    end

  assign cpu_clk_o = slow_act_q ? cnt_q[CW-1] : clk_i;
  assign cko_o     = cko_act_q & cpu_clk_o;
  assign cko_oe_o  = cko_act_q;

  a_r6_slow_at_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(slow_act_q) |-> (cnt_q == '0));
  a_r6_cko_at_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cko_act_q) |-> (cnt_q == '0));
endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock
  import clkctl_pkg::*;
#(
  parameter int STARTUP_CYC = 256,
  parameter int STAB_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic halt_i,
  output logic locked_o
);
  localparam int MAXC = (STARTUP_CYC > STAB_CYC) ? STARTUP_CYC : STAB_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          lock_s;
  lock_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  clkctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pll_lock_i),
    .q_o    (lock_s)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (halt_i) begin
      st_d  = LK_START;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        LK_START:
          if (cnt_q == CW'(STARTUP_CYC - 1)) begin
            st_d  = LK_STAB;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        LK_STAB:
          if (!lock_s) cnt_d = '0;
          else if (cnt_q == CW'(STAB_CYC - 1)) begin
            st_d  = LK_DONE;
            cnt_d = '0;
          end else cnt_d = cnt_q + 1'b1;
        LK_DONE:
          if (!lock_s) begin
            st_d  = LK_STAB;
            cnt_d = '0;
          end
        default: begin
          st_d  = LK_START;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= LK_START;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end

  assign locked_o = (st_q == LK_DONE);

  a_r8_loss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !lock_s) |=> !locked_o);
  a_r9_halt_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !locked_o);
  a_r7_full_stab: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && st_d == LK_DONE) |-> (st_q == LK_STAB && lock_s && cnt_q == CW'(STAB_CYC - 1)));
endmodule

// File: rtl/clkctl.sv
module clkctl
  import clkctl_pkg::*;
#(
  parameter int DIV_LOG2    = 5,
  parameter int STARTUP_CYC = 256,
  parameter int STAB_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       pll_lock_i,
  input  logic       halt_i,
  output logic       cpu_clk_o,
  output logic       cko_o,
  output logic       cko_oe_o
);
  ctrl_t ctrl;
  logic  locked;

  clkctl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .locked_i (locked),
    .ctrl_o   (ctrl),
    .rdata_o  (rdata_o)
  );

  clkctl_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .cpu_clk_o (cpu_clk_o),
    .cko_o     (cko_o),
    .cko_oe_o  (cko_oe_o)
  );

  clkctl_lock #(
    .STARTUP_CYC (STARTUP_CYC),
    .STAB_CYC    (STAB_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_lock_i (pll_lock_i),
    .halt_i     (halt_i),
    .locked_o   (locked)
  );

  a_r10_stat_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == ADDR_STAT && !halt_i && locked && pll_lock_i) |=> locked);
endmodule

// File: tb/clkctl_tb.sv
module clkctl_tb;
  localparam int S = 8;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pll = 1'b1, halt = 1'b0;
  logic       cpu_clk, cko, cko_oe;

  int n_chk = 0, n_bad = 0;
  int ecnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  clkctl #(.DIV_LOG2(5), .STARTUP_CYC(S), .STAB_CYC(T), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pll_lock_i(pll), .halt_i(halt),
    .cpu_clk_o(cpu_clk), .cko_o(cko), .cko_oe_o(cko_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; sel = 0; we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic to_phase0();
    while (ecnt % 32 != 0) edge1();
  endtask

  // one sample per edge at +1ns (oscillator high)
  task automatic sweep_slow(input string req, input bit en);
    int bad = 0, a = 0, e = 0;
    for (int i = 0; i < 64; i++) begin
      edge1();
      e = ((ecnt % 32) >= 16);
      if (cpu_clk != e) begin bad++; a = cpu_clk; end
      if (cko != (en ? e : 0)) begin bad++; a = cko; end
    end
    chk(bad == 0, req, a, e);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int t0, t1;
    #23;
    rst_n = 1;

    // R1 reset state
    #1;
    chk(cko_oe == 0, "R1 cko_oe", cko_oe, 0);
    chk(cpu_clk == clk, "R1 cpu_clk follows osc", cpu_clk, clk);
    rd(0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
    rd(1, d); chk(d == 8'h00, "R1 stat reset", d, 0);

    // R7 lock sweep from reset
    while (ecnt < S + T + 3) begin
      edge1();
      chk(u_dut.rdata_o[0] == 1'b0 || addr == 1, "", 0, 0);
      addr = 1; #1;
      chk(rdata[0] == (ecnt >= S + T), "R7 lock timing", rdata[0], ecnt >= S + T);
    end

    // R2, R5 reserved bits, readback
    wr(0, 8'hFC); rd(0, d); chk(d == 8'h00, "R2 reserved ignored", d, 0);
    wr(0, 8'hFE); rd(0, d); chk(d == 8'h02, "R2 R5 readback", d, 2);
    wr(0, 8'h00); rd(0, d); chk(d == 8'h00, "R5 readback zero", d, 0);
    // R10 status write ignored
    wr(1, 8'h00); rd(1, d); chk(d == 8'h01, "R10 lock unchanged", d, 1);
    wr(1, 8'hFF); rd(0, d); chk(d == 8'h00, "R5 stat write no ctrl change", d, 0);

    // R4 normal: period 10ns
    @(posedge cpu_clk); t0 = $time; @(posedge cpu_clk); t1 = $time;
    chk(t1 - t0 == 10, "R4 normal period", t1 - t0, 10);

    // R6 apply point for slow mode
    edge1();
    while (ecnt % 32 != 5) edge1();
    wr(0, 8'h01);
    begin
      int bad = 0;
      while (ecnt % 32 != 0) begin
        if (cpu_clk != 1) bad++;
        edge1();
      end
      chk(bad == 0 && cpu_clk == 1, "R6 normal until boundary", bad, 0);
      edge1();
      chk(cpu_clk == 0 && ecnt % 32 == 1, "R6 slow after boundary", cpu_clk, 0);
    end
    chk(cko_oe == 0, "R3 oe off", cko_oe, 0);
    sweep_slow("R4 slow phases", 0);
    @(posedge cpu_clk); t0 = $time; @(posedge cpu_clk); t1 = $time;
    chk(t1 - t0 == 320, "R4 slow period", t1 - t0, 320);
    @(posedge cpu_clk); t0 = $time; @(posedge cpu_clk); t1 = $time;
    chk(t1 - t0 == 320, "R4 slow period again", t1 - t0, 320);

    // R3 clock-out in slow mode
    wr(0, 8'h03);
    edge1(); to_phase0(); edge1();
    chk(cko_oe == 1, "R3 oe on", cko_oe, 1);
    sweep_slow("R3 cko slow", 1);

    // R3 clock-out in normal mode
    wr(0, 8'h02);
    edge1(); to_phase0(); edge1();
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (cko != 1 || cpu_clk != 1) bad++;
        @(negedge clk); #1;
        if (cko != 0 || cpu_clk != 0) bad++;
        edge1();
      end
      chk(bad == 0, "R3 R4 cko normal", bad, 0);
    end
    @(posedge cko); t0 = $time; @(posedge cko); t1 = $time;
    chk(t1 - t0 == 10, "R3 cko period", t1 - t0, 10);

    // R3 gating off
    wr(0, 8'h00);
    edge1(); to_phase0(); edge1();
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        if (cko != 0) bad++;
        edge1();
      end
      chk(bad == 0 && cko_oe == 0, "R3 cko gated", bad, 0);
    end

    // R8 loss of pll lock
    @(negedge clk); addr = 1; pll = 0;
    edge1(); edge1(); chk(rdata[0] == 1, "R8 still locked edge2", rdata[0], 1);
    edge1(); chk(rdata[0] == 0, "R8 cleared edge3", rdata[0], 0);
    repeat (5) edge1();
    chk(rdata[0] == 0, "R8 stays clear", rdata[0], 0);
    @(negedge clk); pll = 1;
    for (int k = 1; k <= T + 3; k++) begin
      edge1();
      chk(rdata[0] == (k >= T + 2), "R8 relock", rdata[0], k >= T + 2);
    end

    // R9 halt
    @(negedge clk); halt = 1;
    edge1(); chk(rdata[0] == 0, "R9 halt clears", rdata[0], 0);
    repeat (4) edge1();
    chk(rdata[0] == 0, "R9 held in halt", rdata[0], 0);
    @(negedge clk); halt = 0;
    for (int k = 1; k <= S + T + 2; k++) begin
      edge1();
      chk(rdata[0] == (k >= S + T), "R9 restart timing", rdata[0], k >= S + T);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule